// File: doc/BRIEF.md
# ATA Task-File Register Decoder

This block holds the host-visible register file of an ATA device: the command block (data, error/features, sector count, sector number, cylinder low, cylinder high, drive/head, status/command) and the control block (device control on write, alternate status on read). The host reaches it through a byte-wide register port that also permits a 16-bit access to the data register. Every accepted access that matters to the device protocol is reported as a one-cycle action event. The downstream protocol state machine consumes these events; moving the data itself is not done here.

When the host writes the command register, the decoder classifies the opcode, applies the LBA-only and zero-means-256 sector rules, and publishes a command descriptor (class, starting LBA, byte count) for one cycle. At the same edge it updates the status register. A software reset through the device-control register overrides any command in progress.

The controller has four states. IDLE moves to DECODE on an accepted command write. DECODE moves to ISSUE on the next edge, and ISSUE returns to IDLE one edge later. Any of the three goes to RESET when the software-reset bit is written as 1. RESET goes back to IDLE when a device-control write clears that bit.

Top module: `atf_top`

## Requirements
- R1: After reset the status register reads 0x40 (ready only), the other byte registers read 0, the interrupt mask is 0, no event is pending and no descriptor is valid.
- R2: A 16-bit access (`hst_wide`=1) is legal only at command-block offset 0. An illegal access is one of these: a 16-bit access at any other offset, a 16-bit access to the control block, or any control-block access at an offset other than 6. It pulses `acc_err` one cycle after the access. It changes no register, returns no read data (`hst_rvalid`=0) and raises no event.
- R3: A status read (command block, offset 7) returns the status byte and raises event 1. A control-block read at offset 6 returns the same byte and raises no event.
- R4: Event codes appear on `evt_code` for exactly one cycle, in the cycle after the access. The codes are: 2 for a data read at offset 0, 3 for a data write at offset 0, 4 for a command write at offset 7, and 5 for a drive/head write at offset 6.
- R5: Writing device control (control offset 6) latches bit 1 into `irq_mask`. If bit 2 is 1, the write raises event 6, sets status to 0x80 and enters RESET, dropping any command still being decoded. Writing bit 2 as 0 while in RESET raises event 7, sets status to 0x40 and returns to IDLE. Command-block writes in RESET have no effect.
- R6: A sector count of 0 means 256 sectors. For read, write and DMA commands the byte count is the number of sectors times 512.
- R7: The starting LBA is {drive/head[3:0], cylinder high, cylinder low, sector number}.
- R8: A read, write or DMA opcode whose drive/head bit 6 (LBA) is 0 is issued as class 5 (abort). Status becomes 0x41 and the error register (offset 1) becomes 0x04.
- R9: An opcode outside the supported set (0x20, 0xC4, 0x30, 0xC5, 0xC8, 0xCA, 0xEC, 0xF8, 0xE5, 0xE0, 0xE7, 0x40, 0xEF, 0xC6) is issued as class 5, with status 0x41 and error 0x04.
- R10: Opcode 0xF8 writes capacity−1 back into the registers: bits 7:0 go to sector number, bits 15:8 to cylinder low, bits 23:16 to cylinder high, and bits 27:24 to drive/head[3:0]. Drive/head[7:4] is kept. The class is 0.
- R11: An accepted command sets status to 0x C0 (busy and ready; DRQ, DF and ERR cleared) and clears the error register. A `xfer_done` pulse then clears the busy bit.
- R12: `cmd_valid` is a single-cycle pulse in the second cycle after the command-write edge. While a command is being decoded or issued, command-block writes are ignored.
- R13: Class encoding: 0 no data (0xF8, 0xE5, 0xE0, 0xE7, 0x40, 0xEF, 0xC6); 1 PIO in (0x20, 0xC4, and 0xEC with a 512-byte count and no LBA rule); 2 PIO out (0x30, 0xC5); 3 DMA to host (0xC8); 4 DMA from host (0xCA); 5 abort. Classes 0 and 5 carry byte count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_ctl | input | 1 | 1 selects the control block, 0 the command block |
| hst_ofs | input | 3 | Register offset |
| hst_wide | input | 1 | 16-bit access |
| hst_wdata | input | 16 | Write data (low byte for byte access) |
| hst_rdata | output | 16 | Read data, registered |
| hst_rvalid | output | 1 | Read data valid |
| acc_err | output | 1 | Illegal access pulse |
| evt_code | output | 3 | Action event to the protocol machine, 0 = none |
| cmd_valid | output | 1 | Command descriptor valid pulse |
| cmd_class | output | 3 | Command class |
| cmd_lba | output | 28 | Starting sector |
| cmd_bytes | output | 18 | Command byte count |
| irq_mask | output | 1 | Latched interrupt-disable bit |
| cap_sectors | input | 28 | Device capacity in sectors |
| xfer_done | input | 1 | Protocol machine reports the command finished |

## Verification
Two collisions get direct checks. In the first, a host status read lands on the same edge at which the decoder publishes the new status of an accepted command. The read issued in DECODE must return the pre-command value 0x40, while a read one cycle later must return 0x C0, and `cmd_valid` must be high in the cycle between them. In the second, a software-reset write lands on the DECODE edge of a command. Reset must win: the bench expects the reset event right after the command event, no descriptor pulse, and a status of 0x80.

// File: rtl/atf_pkg.sv
package atf_pkg;

    typedef enum logic [2:0] {
        EV_NONE     = 3'd0,
        EV_STAT_RD  = 3'd1,
        EV_DATA_RD  = 3'd2,
        EV_DATA_WR  = 3'd3,
        EV_CMD_WR   = 3'd4,
        EV_SEL_WR   = 3'd5,
        EV_SRST_SET = 3'd6,
        EV_SRST_CLR = 3'd7
    } atf_evt_e;

    typedef enum logic [2:0] {
        CL_NODATA    = 3'd0,
        CL_PIO_IN    = 3'd1,
        CL_PIO_OUT   = 3'd2,
        CL_DMA_TOHST = 3'd3,
        CL_DMA_FRHST = 3'd4,
        CL_ABORT     = 3'd5
    } atf_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_ISSUE  = 2'd2,
        ST_RESET  = 2'd3
    } atf_state_e;

    // register offsets (command block unless noted)
    localparam logic [2:0] OFS_DATA   = 3'd0;
    localparam logic [2:0] OFS_ERR    = 3'd1;
    localparam logic [2:0] OFS_CNT    = 3'd2;
    localparam logic [2:0] OFS_SNO    = 3'd3;
    localparam logic [2:0] OFS_CYLLO  = 3'd4;
    localparam logic [2:0] OFS_CYLHI  = 3'd5;
    localparam logic [2:0] OFS_DRV    = 3'd6;
    localparam logic [2:0] OFS_CMD    = 3'd7;
    localparam logic [2:0] OFS_DEVCTL = 3'd6;   // control block

    // status byte values
    localparam logic [7:0] STAT_READY = 8'h40;
    localparam logic [7:0] STAT_SRST  = 8'h80;
    localparam logic [7:0] STAT_BUSY  = 8'hC0;
    localparam logic [7:0] STAT_FAIL  = 8'h41;
    localparam logic [7:0] ERR_ABORT  = 8'h04;
    localparam int         BSY_BIT    = 7;

    localparam int DRV_LBA_BIT  = 6;
    localparam int CTL_SRST_BIT = 2;
    localparam int CTL_MASK_BIT = 1;

    // opcodes
    localparam logic [7:0] OP_RD_PIO    = 8'h20;
    localparam logic [7:0] OP_RD_MULTI  = 8'hC4;
    localparam logic [7:0] OP_WR_PIO    = 8'h30;
    localparam logic [7:0] OP_WR_MULTI  = 8'hC5;
    localparam logic [7:0] OP_RD_DMA    = 8'hC8;
    localparam logic [7:0] OP_WR_DMA    = 8'hCA;
    localparam logic [7:0] OP_IDENT     = 8'hEC;
    localparam logic [7:0] OP_NATIVEMAX = 8'hF8;
    localparam logic [7:0] OP_CHKPWR    = 8'hE5;
    localparam logic [7:0] OP_STANDBY   = 8'hE0;
    localparam logic [7:0] OP_FLUSH     = 8'hE7;
    localparam logic [7:0] OP_VERIFY    = 8'h40;
    localparam logic [7:0] OP_SETFEAT   = 8'hEF;
    localparam logic [7:0] OP_SETMULT   = 8'hC6;

endpackage

// File: rtl/atf_access_decode.sv
module atf_access_decode
    import atf_pkg::*;
(
    input  logic       wr,
    input  logic       rd,
    input  logic       ctl,
    input  logic       wide,
    input  logic [2:0] ofs,
    input  logic       srst_bit,
    input  atf_state_e state,
    output logic       acc_err,
    output logic       rd_ok,
    output logic [7:0] cmd_we,
    output logic       ctl_we,
    output atf_evt_e   evt
);

    logic legal;
    logic wr_ok;

    always_comb begin
        if (ctl) legal = !wide && (ofs == OFS_DEVCTL);
        else     legal = !wide || (ofs == OFS_DATA);

        acc_err = (wr || rd) && !legal;
        rd_ok   = rd && !wr && legal;
        wr_ok   = wr && legal && !ctl && (state == ST_IDLE);
        ctl_we  = wr && legal && ctl;

        for (int i = 0; i < 8; i++) begin
            cmd_we[i] = wr_ok && (ofs == 3'(i));
        end

        evt = EV_NONE;
        if (ctl_we) begin
            if (srst_bit)               evt = EV_SRST_SET;
            else if (state == ST_RESET) evt = EV_SRST_CLR;
        end else if (wr_ok) begin
            if (ofs == OFS_DATA)     evt = EV_DATA_WR;
            else if (ofs == OFS_DRV) evt = EV_SEL_WR;
            else if (ofs == OFS_CMD) evt = EV_CMD_WR;
        end else if (rd_ok && !ctl) begin
            if (ofs == OFS_DATA)      evt = EV_DATA_RD;
            else if (ofs == OFS_CMD)  evt = EV_STAT_RD;
        end
    end

endmodule

// File: rtl/atf_cmd_classify.sv
module atf_cmd_classify
    import atf_pkg::*;
#(
    parameter int SECT_BYTES = 512,
    parameter int ID_BYTES   = 512,
    parameter int BCW        = $clog2(256 * SECT_BYTES) + 1
) (
    input  logic [7:0]     opcode,
    input  logic [7:0]     seccnt,
    input  logic [7:0]     drv,
    output atf_cls_e       cls,
    output logic [BCW-1:0] bytes,
    output logic           native_max
);

    logic [8:0]     nsec;
    logic [BCW-1:0] sect_bytes;
    logic           lba_ok;

    always_comb begin
        nsec       = (seccnt == 8'd0) ? 9'd256 : {1'b0, seccnt};
        sect_bytes = BCW'(nsec) * BCW'(SECT_BYTES);
        lba_ok     = drv[DRV_LBA_BIT];
        native_max = 1'b0;
        cls        = CL_ABORT;
        bytes      = '0;

        case (opcode)
            OP_RD_PIO, OP_RD_MULTI: begin
                cls   = lba_ok ? CL_PIO_IN : CL_ABORT;
                bytes = lba_ok ? sect_bytes : '0;
            end
            OP_WR_PIO, OP_WR_MULTI: begin
                cls   = lba_ok ? CL_PIO_OUT : CL_ABORT;
                bytes = lba_ok ? sect_bytes : '0;
            end
            OP_RD_DMA: begin
                cls   = lba_ok ? CL_DMA_TOHST : CL_ABORT;
                bytes = lba_ok ? sect_bytes : '0;
            end
            OP_WR_DMA: begin
                cls   = lba_ok ? CL_DMA_FRHST : CL_ABORT;
                bytes = lba_ok ? sect_bytes : '0;
            end
            OP_IDENT: begin
                cls   = CL_PIO_IN;
                bytes = BCW'(ID_BYTES);
            end
            OP_NATIVEMAX: begin
                cls        = CL_NODATA;
                native_max = 1'b1;
            end
            OP_CHKPWR, OP_STANDBY, OP_FLUSH,
            OP_VERIFY, OP_SETFEAT, OP_SETMULT: begin
                cls = CL_NODATA;
            end
            default: begin
                cls = CL_ABORT;
            end
        endcase
    end

endmodule

// File: rtl/atf_top.sv
module atf_top
    import atf_pkg::*;
#(
    parameter int SECT_BYTES = 512,
    parameter int ID_BYTES   = 512,
    parameter int LBAW       = 28,
    parameter int BCW        = $clog2(256 * SECT_BYTES) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hst_wr,
    input  logic            hst_rd,
    input  logic            hst_ctl,
    input  logic [2:0]      hst_ofs,
    input  logic            hst_wide,
    input  logic [15:0]     hst_wdata,
    output logic [15:0]     hst_rdata,
    output logic            hst_rvalid,
    output logic            acc_err,
    output logic [2:0]      evt_code,
    output logic            cmd_valid,
    output logic [2:0]      cmd_class,
    output logic [LBAW-1:0] cmd_lba,
    output logic [BCW-1:0]  cmd_bytes,
    output logic            irq_mask,
    input  logic [LBAW-1:0] cap_sectors,
    input  logic            xfer_done
);

    localparam int HEADW = LBAW - 24;

    atf_state_e state_q, state_d;

    logic [15:0]     data_q;
    logic [7:0]      err_q, cnt_q, sno_q, cyllo_q, cylhi_q, drv_q, cmd_q, stat_q;
    logic            nien_q;
    atf_cls_e        cls_q;
    logic [LBAW-1:0] lba_q;
    logic [BCW-1:0]  bytes_q;
    atf_evt_e        evt_q;
    logic            acc_err_q;

    logic            dec_err, dec_rd_ok, dec_ctl_we;
    logic [7:0]      dec_we;
    atf_evt_e        dec_evt;
    atf_cls_e        cl_cls;
    logic [BCW-1:0]  cl_bytes;
    logic            cl_native;
    logic [LBAW-1:0] cap_m1;
    logic            srst_set, srst_clr;

    atf_access_decode u_acc (
        .wr       (hst_wr),
        .rd       (hst_rd),
        .ctl      (hst_ctl),
        .wide     (hst_wide),
        .ofs      (hst_ofs),
        .srst_bit (hst_wdata[CTL_SRST_BIT]),
        .state    (state_q),
        .acc_err  (dec_err),
        .rd_ok    (dec_rd_ok),
        .cmd_we   (dec_we),
        .ctl_we   (dec_ctl_we),
        .evt      (dec_evt)
    );

    atf_cmd_classify #(
        .SECT_BYTES (SECT_BYTES),
        .ID_BYTES   (ID_BYTES),
        .BCW        (BCW)
    ) u_cls (
        .opcode     (cmd_q),
        .seccnt     (cnt_q),
        .drv        (drv_q),
        .cls        (cl_cls),
        .bytes      (cl_bytes),
        .native_max (cl_native)
    );

    assign srst_set = (dec_evt == EV_SRST_SET);
    assign srst_clr = (dec_evt == EV_SRST_CLR);
    assign cap_m1   = cap_sectors - LBAW'(1);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (srst_set)                state_d = ST_RESET;
                else if (dec_evt == EV_CMD_WR) state_d = ST_DECODE;
            end
            ST_DECODE: state_d = srst_set ? ST_RESET : ST_ISSUE;
            ST_ISSUE:  state_d = srst_set ? ST_RESET : ST_IDLE;
            ST_RESET:  if (srst_clr) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Moore outputs
    always_comb begin
        cmd_valid = (state_q == ST_ISSUE);
        cmd_class = cls_q;
        cmd_lba   = lba_q;
        cmd_bytes = bytes_q;
        evt_code  = evt_q;
        acc_err   = acc_err_q;
        irq_mask  = nien_q;
    end

    // register file and descriptor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q    <= '0;
            err_q     <= '0;
            cnt_q     <= '0;
            sno_q     <= '0;
            cyllo_q   <= '0;
            cylhi_q   <= '0;
            drv_q     <= '0;
            cmd_q     <= '0;
            stat_q    <= STAT_READY;
            nien_q    <= 1'b0;
            cls_q     <= CL_NODATA;
            lba_q     <= '0;
            bytes_q   <= '0;
            evt_q     <= EV_NONE;
            acc_err_q <= 1'b0;
        end else begin
            evt_q     <= dec_evt;
            acc_err_q <= dec_err;

            if (dec_we[OFS_DATA]) begin
                if (hst_wide) data_q <= hst_wdata;
                else          data_q[7:0] <= hst_wdata[7:0];
            end
            if (dec_we[OFS_CNT])   cnt_q   <= hst_wdata[7:0];
            if (dec_we[OFS_SNO])   sno_q   <= hst_wdata[7:0];
            if (dec_we[OFS_CYLLO]) cyllo_q <= hst_wdata[7:0];
            if (dec_we[OFS_CYLHI]) cylhi_q <= hst_wdata[7:0];
            if (dec_we[OFS_DRV])   drv_q   <= hst_wdata[7:0];
            if (dec_we[OFS_CMD])   cmd_q   <= hst_wdata[7:0];

            if (xfer_done && state_q != ST_RESET) stat_q[BSY_BIT] <= 1'b0;

            if (state_q == ST_DECODE && !srst_set) begin
                cls_q   <= cl_cls;
                bytes_q <= cl_bytes;
                lba_q   <= {drv_q[HEADW-1:0], cylhi_q, cyllo_q, sno_q};
                if (cl_cls == CL_ABORT) begin
                    stat_q <= STAT_FAIL;
                    err_q  <= ERR_ABORT;
                end else begin
                    stat_q <= STAT_BUSY;
                    err_q  <= '0;
                end
                if (cl_native) begin
                    sno_q   <= cap_m1[7:0];
                    cyllo_q <= cap_m1[15:8];
                    cylhi_q <= cap_m1[23:16];
                    drv_q   <= {drv_q[7:HEADW], cap_m1[LBAW-1:24]};
                end
            end

            if (dec_ctl_we) begin
                nien_q <= hst_wdata[CTL_MASK_BIT];
                if (srst_set)      stat_q <= STAT_SRST;
                else if (srst_clr) stat_q <= STAT_READY;
            end
        end
    end

    // read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hst_rdata  <= '0;
            hst_rvalid <= 1'b0;
        end else begin
            hst_rvalid <= dec_rd_ok;
            if (dec_rd_ok) begin
                if (hst_wide)     hst_rdata <= data_q;
                else if (hst_ctl) hst_rdata <= {8'h00, stat_q};
                else begin
                    unique case (hst_ofs)
                        OFS_DATA:  hst_rdata <= {8'h00, data_q[7:0]};
                        OFS_ERR:   hst_rdata <= {8'h00, err_q};
                        OFS_CNT:   hst_rdata <= {8'h00, cnt_q};
                        OFS_SNO:   hst_rdata <= {8'h00, sno_q};
                        OFS_CYLLO: hst_rdata <= {8'h00, cyllo_q};
                        OFS_CYLHI: hst_rdata <= {8'h00, cylhi_q};
                        OFS_DRV:   hst_rdata <= {8'h00, drv_q};
                        OFS_CMD:   hst_rdata <= {8'h00, stat_q};
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/atf_chk.sv
module atf_chk
    import atf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] evt_code,
    input logic       acc_err,
    input logic       cmd_valid,
    input logic [2:0] cmd_class,
    input logic [7:0] stat_q
);

    // R2: a rejected access raises no event
    a_r2_err_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (evt_code == EV_NONE));

    // R12: descriptor valid lasts one cycle
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R12: descriptor follows the command-write event by one cycle
    a_r12_after_cmd_evt: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(evt_code) == EV_CMD_WR));

    // R11: accepted command shows busy status while issued
    a_r11_busy_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_class != CL_ABORT) |-> (stat_q == STAT_BUSY));

    // R8: aborted command shows error status
    a_r8_abort_status: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_class == CL_ABORT) |-> (stat_q == STAT_FAIL));

    // R5: reset event comes with reset status
    a_r5_srst_status: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_code == EV_SRST_SET) |-> (stat_q == STAT_SRST));

endmodule

bind atf_top atf_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_code  (evt_code),
    .acc_err   (acc_err),
    .cmd_valid (cmd_valid),
    .cmd_class (cmd_class),
    .stat_q    (stat_q)
);

// File: tb/atf_top_tb.sv
`timescale 1ns/1ps
module atf_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_wr = 0, hst_rd = 0, hst_ctl = 0, hst_wide = 0;
    logic [2:0]  hst_ofs = '0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic        hst_rvalid, acc_err, cmd_valid, irq_mask;
    logic [2:0]  evt_code, cmd_class;
    logic [27:0] cmd_lba;
    logic [17:0] cmd_bytes;
    logic [27:0] cap_sectors = 28'h3456789;
    logic        xfer_done = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit mon_on  = 0;
    bit done_flag = 0;
    int exp_q[$];

    always #2 clk = ~clk;

    atf_top u_dut (
        .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_ctl(hst_ctl), .hst_ofs(hst_ofs), .hst_wide(hst_wide),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid),
        .acc_err(acc_err), .evt_code(evt_code), .cmd_valid(cmd_valid),
        .cmd_class(cmd_class), .cmd_lba(cmd_lba), .cmd_bytes(cmd_bytes),
        .irq_mask(irq_mask), .cap_sectors(cap_sectors), .xfer_done(xfer_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // event monitor: pops expected events as the design raises them
    always @(negedge clk) begin
        if (mon_on && evt_code != 3'd0) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R4 unexpected event actual=%0d expected=none", evt_code);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(evt_code) != e) begin
                    n_fail++;
                    $display("FAIL R4 event actual=%0d expected=%0d", evt_code, e);
                end
            end
        end
    end

    // all tasks are entered at a falling edge and return at the next one
    task automatic hwrite(input bit ctl, input logic [2:0] ofs, input bit wide,
                          input logic [15:0] d, input int ev);
        if (ev != 0) exp_q.push_back(ev);
        hst_wr = 1; hst_ctl = ctl; hst_ofs = ofs; hst_wide = wide; hst_wdata = d;
        @(negedge clk);
        hst_wr = 0; hst_ctl = 0; hst_wide = 0;
    endtask

    task automatic hread(input bit ctl, input logic [2:0] ofs, input bit wide,
                         input int ev, output logic [15:0] q, output logic v, output logic ae);
        if (ev != 0) exp_q.push_back(ev);
        hst_rd = 1; hst_ctl = ctl; hst_ofs = ofs; hst_wide = wide;
        @(negedge clk);
        hst_rd = 0; hst_ctl = 0; hst_wide = 0;
        q = hst_rdata; v = hst_rvalid; ae = acc_err;
    endtask

    task automatic rbyte(input logic [2:0] ofs, input logic [7:0] exp, input string tag);
        logic [15:0] q; logic v, ae;
        hread(0, ofs, 0, (ofs == 3'd7) ? 1 : ((ofs == 3'd0) ? 2 : 0), q, v, ae);
        chk(tag, {15'd0, v, q}, {15'd0, 1'b1, 8'h00, exp});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_done();
        xfer_done = 1;
        @(negedge clk);
        xfer_done = 0;
    endtask

    // called in the cycle after the DECODE edge
    task automatic expect_cmd(input logic [2:0] cls, input logic [27:0] lba,
                              input logic [17:0] bytes, input string tag);
        chk({tag, " valid"}, {31'd0, cmd_valid}, 32'd1);
        chk({tag, " class"}, {29'd0, cmd_class}, {29'd0, cls});
        chk({tag, " lba"},   {4'd0, cmd_lba}, {4'd0, lba});
        chk({tag, " bytes"}, {14'd0, cmd_bytes}, {14'd0, bytes});
    endtask

    task automatic issue(input logic [7:0] op);
        hwrite(0, 3'd7, 0, {8'h00, op}, 4);
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] q; logic v, ae;
        idle(3);
        rst_n = 1;
        mon_on = 1;
        @(negedge clk);

        // R1 reset state
        rbyte(3'd7, 8'h40, "R1 status after reset");
        rbyte(3'd2, 8'h00, "R1 sector count after reset");
        chk("R1 irq mask", {31'd0, irq_mask}, 32'd0);
        chk("R1 no descriptor", {31'd0, cmd_valid}, 32'd0);

        // R2 illegal accesses
        hread(0, 3'd2, 1, 0, q, v, ae);
        chk("R2 wide read err", {30'd0, ae, v}, 32'd2);
        hwrite(0, 3'd3, 1, 16'h55AA, 0);
        chk("R2 wide write err", {31'd0, acc_err}, 32'd1);
        rbyte(3'd3, 8'h00, "R2 sector number untouched");
        hread(1, 3'd2, 0, 0, q, v, ae);
        chk("R2 bad control offset", {30'd0, ae, v}, 32'd2);

        // R3 alternate status: same value, no event
        hread(1, 3'd6, 0, 0, q, v, ae);
        chk("R3 alt status", {15'd0, v, q}, {15'd0, 1'b1, 16'h0040});

        // R4 data register wide path
        hwrite(0, 3'd0, 1, 16'hBEEF, 3);
        hread(0, 3'd0, 1, 2, q, v, ae);
        chk("R4 data wide readback", {15'd0, v, q}, {15'd0, 1'b1, 16'hBEEF});

        // R6 R7 R11 R12 R13: PIO read, collision with status read
        hwrite(0, 3'd2, 0, 16'h0003, 0);
        hwrite(0, 3'd3, 0, 16'h0010, 0);
        hwrite(0, 3'd4, 0, 16'h0020, 0);
        hwrite(0, 3'd5, 0, 16'h0030, 0);
        hwrite(0, 3'd6, 0, 16'h00E5, 5);
        hwrite(0, 3'd7, 0, 16'h0020, 4);
        hread(0, 3'd7, 0, 1, q, v, ae);
        chk("R11 status read on decode edge is old", {16'd0, q}, 32'h40);
        expect_cmd(3'd1, 28'h5302010, 18'd1536, "R7 R13 pio read");
        @(negedge clk);
        chk("R12 pulse ends", {31'd0, cmd_valid}, 32'd0);
        rbyte(3'd7, 8'hC0, "R11 busy status");
        rbyte(3'd1, 8'h00, "R11 error cleared");
        pulse_done();
        rbyte(3'd7, 8'h40, "R11 done clears busy");

        // R6 zero count, DMA from host
        hwrite(0, 3'd2, 0, 16'h0000, 0);
        issue(8'hCA);
        expect_cmd(3'd4, 28'h5302010, 18'd131072, "R6 count zero dma");
        @(negedge clk);
        pulse_done();

        // R13 PIO out and DMA to host
        hwrite(0, 3'd2, 0, 16'h0002, 0);
        issue(8'h30);
        expect_cmd(3'd2, 28'h5302010, 18'd1024, "R13 pio out");
        @(negedge clk);
        issue(8'hC8);
        expect_cmd(3'd3, 28'h5302010, 18'd1024, "R13 dma to host");
        @(negedge clk);
        pulse_done();

        // R8 CHS access rejected
        hwrite(0, 3'd6, 0, 16'h00A5, 5);
        issue(8'h30);
        chk("R8 class abort", {29'd0, cmd_class}, 32'd5);
        chk("R8 bytes zero", {14'd0, cmd_bytes}, 32'd0);
        @(negedge clk);
        rbyte(3'd7, 8'h41, "R8 status");
        rbyte(3'd1, 8'h04, "R8 error code");

        // R9 unsupported opcode, then identify clears the error
        hwrite(0, 3'd6, 0, 16'h00E5, 5);
        issue(8'h99);
        chk("R9 class abort", {29'd0, cmd_class}, 32'd5);
        @(negedge clk);
        rbyte(3'd7, 8'h41, "R9 status");
        issue(8'hEC);
        chk("R13 identify class", {29'd0, cmd_class}, 32'd1);
        chk("R13 identify bytes", {14'd0, cmd_bytes}, 32'd512);
        @(negedge clk);
        rbyte(3'd1, 8'h00, "R11 identify clears error");
        pulse_done();

        // R10 native max
        hwrite(0, 3'd6, 0, 16'h00E0, 5);
        issue(8'hF8);
        chk("R10 class", {29'd0, cmd_class}, 32'd0);
        @(negedge clk);
        rbyte(3'd3, 8'h88, "R10 sector number");
        rbyte(3'd4, 8'h67, "R10 cylinder low");
        rbyte(3'd5, 8'h45, "R10 cylinder high");
        rbyte(3'd6, 8'hE3, "R10 drive head");
        pulse_done();

        // R12 writes ignored while decoding
        hwrite(0, 3'd7, 0, 16'h00E7, 4);
        hwrite(0, 3'd3, 0, 16'h0077, 0);
        chk("R12 flush issued", {31'd0, cmd_valid}, 32'd1);
        @(negedge clk);
        rbyte(3'd3, 8'h88, "R12 busy write ignored");
        pulse_done();

        // R5 software reset with mask, command ignored
        hwrite(1, 3'd6, 0, 16'h0006, 6);
        chk("R5 irq mask latched", {31'd0, irq_mask}, 32'd1);
        rbyte(3'd7, 8'h80, "R5 reset status");
        hwrite(0, 3'd7, 0, 16'h0020, 0);
        chk("R5 no command in reset", {31'd0, cmd_valid}, 32'd0);
        @(negedge clk);
        chk("R5 still no command", {31'd0, cmd_valid}, 32'd0);
        hwrite(1, 3'd6, 0, 16'h0002, 7);
        rbyte(3'd7, 8'h40, "R5 reset cleared");
        chk("R5 mask kept", {31'd0, irq_mask}, 32'd1);

        // R5 reset on the decode edge drops the command
        hwrite(0, 3'd7, 0, 16'h0020, 4);
        hwrite(1, 3'd6, 0, 16'h0004, 6);
        chk("R5 command dropped", {31'd0, cmd_valid}, 32'd0);
        @(negedge clk);
        chk("R5 command still dropped", {31'd0, cmd_valid}, 32'd0);
        rbyte(3'd7, 8'h80, "R5 reset won");
        hwrite(1, 3'd6, 0, 16'h0000, 7);
        chk("R5 mask cleared", {31'd0, irq_mask}, 32'd0);

        idle(3);
        chk("R4 all expected events seen", exp_q.size(), 32'd0);
        if (!done_flag) begin
            done_flag = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done_flag) begin
            done_flag = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule